// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block arbitrates interrupt requests for a small 8-bit controller core. Each source has a sticky request flag. A source event sets the flag, and it stays set until the flag is serviced or cleared by software. Each source also has its own enable bit. A single global enable gates all sources, and the core's call-stack-full indication can hold off any call. When a request may be taken, the block picks the lowest-numbered pending and enabled source. On the next clock edge it raises a one-cycle call strobe together with that source's vector address.

Servicing is atomic with the strobe. On the same edge, the serviced flag is cleared and the global enable drops to 0, so a second interrupt cannot nest. Software sets the global enable again when it returns. A register write port lets software set or clear flags, load the enable mask and write the global enable. The current flags, enables and global enable are driven out as read-back values.

The default configuration has five sources: compare P and compare A of two timers, and a memory write-complete event.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every request flag, every enable bit, the global enable and the call strobe are 0.
- R2: A one-cycle pulse on a source event sets that source's flag on the next clock edge. The flag stays set while its enable is 0, and no call is made in that case.
- R3: A call strobe is raised on the clock edge after a cycle in which the global enable is 1, the stack-full input is 0, and at least one source has both its flag and its enable set. No strobe is raised otherwise.
- R4: The call strobe lasts exactly one cycle. The vector output during the strobe is 4 + 4*i for the selected source i, with source 0 at address 0x04.
- R5: On the edge that raises the strobe, the selected source's flag and the global enable are both cleared.
- R6: When several enabled requests are pending, the lowest-numbered source is served. All other flags stay set.
- R7: While stack-full is 1, no call is made, and flags and the global enable are left unchanged. The pending call is made on the edge after stack-full returns to 0.
- R8: A source event arriving in the same cycle as that source's service clear, or as a software clear of that flag, leaves the flag set.
- R9: The register write port is decoded by a 2-bit address:
  - address 0 sets the flags selected by the data mask;
  - address 1 clears the flags selected by the data mask;
  - address 2 loads the enable mask;
  - address 3 loads the global enable from data bit 0.
- R10: A flag that became pending while its enable was 0 is served once the enable is set, provided the global enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEvent | input | NUM_SRC | Per-source event pulses |
| stackFull | input | 1 | Call stack of the core is full |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register write address |
| regData | input | NUM_SRC | Register write data |
| callStrobe | output | 1 | One-cycle vector call request |
| callVector | output | VEC_W | Vector address of the call |
| flagState | output | NUM_SRC | Current request flags |
| enState | output | NUM_SRC | Current enable mask |
| gieState | output | 1 | Current global enable |

## Verification
The arbiter is swept over every combination of the five pending flags and the five enable bits. Each combination is checked for whether a call is made, which vector is chosen, and which flags remain afterwards. This separates enable gating from priority order and from the single-flag clear. Directed patterns then cover the remaining cases:
- holding stack-full high to show that a call is suppressed, not lost;
- leaving an enable at 0 to show that the flag is kept but no call is made;
- driving an event in the same cycle as a hardware clear or a software clear, where the set must win.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  localparam int IDX_MAXW = 8;

  typedef struct packed {
    logic                take;
    logic [IDX_MAXW-1:0] selIdx;
  } irqCtrl_t;
endpackage

// File: rtl/irq_vector_control.sv
module irq_vector_control
  import irq_vector_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] flagQ,
  input  logic [NUM_SRC-1:0] enQ,
  input  logic               gieQ,
  input  logic               stackFull,
  output irqCtrl_t           ctl
);
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] grant;

  assign pending = flagQ & enQ;

  // Fixed priority: the loop runs downward, so the lowest index is written last and wins.
  always_comb begin
    ctl.selIdx = '0;
    grant      = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        ctl.selIdx = IDX_MAXW'(i);
        grant      = NUM_SRC'(1) << i;
      end
    end
    ctl.take = gieQ && !stackFull && (|pending);
  end

  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R6

  AST_GRANT_IS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    ((grant & ~pending) == '0)); // R3

  AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    stackFull |-> !ctl.take); // R7
endmodule

// File: rtl/irq_vector_datapath.sv
module irq_vector_datapath
  import irq_vector_pkg::*;
#(
  parameter int NUM_SRC    = 5,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 4,
  parameter int VEC_STRIDE = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               stackFull,
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic [NUM_SRC-1:0] regData,
  input  irqCtrl_t           ctl,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [NUM_SRC-1:0] enQ,
  output logic               gieQ,
  output logic               callStrobe,
  output logic [VEC_W-1:0]   callVector
);
  localparam logic [1:0] ADDR_SET = 2'd0;
  localparam logic [1:0] ADDR_CLR = 2'd1;
  localparam logic [1:0] ADDR_EN  = 2'd2;
  localparam logic [1:0] ADDR_GIE = 2'd3;

  logic [NUM_SRC-1:0] swSet, swClr, svcClr, flagNext;
  logic               gieWr, enWr;
  logic [VEC_W-1:0]   vecNext;

  assign swSet  = (regWr && regAddr == ADDR_SET) ? regData : '0;
  assign swClr  = (regWr && regAddr == ADDR_CLR) ? regData : '0;
  assign enWr   = regWr && regAddr == ADDR_EN;
  assign gieWr  = regWr && regAddr == ADDR_GIE;
  assign svcClr = ctl.take ? (NUM_SRC'(1) << ctl.selIdx) : '0;
  assign vecNext = VEC_W'(VEC_BASE) + VEC_W'(ctl.selIdx) * VEC_W'(VEC_STRIDE);

  // An event or a software set always wins over any clear in the same cycle.
  for (genvar i = 0; i < NUM_SRC; i++) begin : gFlag
    assign flagNext[i] = (flagQ[i] & ~svcClr[i] & ~swClr[i]) | swSet[i] | srcEvent[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ      <= '0;
      enQ        <= '0;
      gieQ       <= 1'b0;
      callStrobe <= 1'b0;
      callVector <= '0;
    end else begin
      flagQ      <= flagNext;
      callStrobe <= ctl.take;
      if (enWr)          enQ  <= regData;
      if (gieWr)         gieQ <= regData[0];
      else if (ctl.take) gieQ <= 1'b0;
      if (ctl.take)      callVector <= vecNext;
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    callStrobe |=> !callStrobe); // R4

  AST_SERVICE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    (callStrobe && !$past(gieWr)) |-> !gieQ); // R5

  AST_CALL_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    callStrobe |-> $past(gieQ)); // R3

  AST_CALL_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    callStrobe |-> ($past(flagQ & enQ) != '0)); // R3

  AST_FULL_BLOCKS_CALL: assert property (@(posedge clk) disable iff (!rstN)
    $past(stackFull) |-> !callStrobe); // R7

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    $past(srcEvent[0]) |-> flagQ[0]); // R8
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
#(
  parameter int NUM_SRC    = 5,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 4,
  parameter int VEC_STRIDE = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               stackFull,
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic [NUM_SRC-1:0] regData,
  output logic               callStrobe,
  output logic [VEC_W-1:0]   callVector,
  output logic [NUM_SRC-1:0] flagState,
  output logic [NUM_SRC-1:0] enState,
  output logic               gieState
);
  irqCtrl_t ctl;

  irq_vector_control #(.NUM_SRC(NUM_SRC)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .flagQ     (flagState),
    .enQ       (enState),
    .gieQ      (gieState),
    .stackFull (stackFull),
    .ctl       (ctl)
  );

  irq_vector_datapath #(
    .NUM_SRC    (NUM_SRC),
    .VEC_W      (VEC_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .srcEvent   (srcEvent),
    .stackFull  (stackFull),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regData    (regData),
    .ctl        (ctl),
    .flagQ      (flagState),
    .enQ        (enState),
    .gieQ       (gieState),
    .callStrobe (callStrobe),
    .callVector (callVector)
  );
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] srcEvent = '0;
  logic         stackFull = 1'b0;
  logic         regWr = 1'b0;
  logic [1:0]   regAddr = '0;
  logic [N-1:0] regData = '0;
  logic         callStrobe;
  logic [7:0]   callVector;
  logic [N-1:0] flagState, enState;
  logic         gieState;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .stackFull(stackFull),
    .regWr(regWr), .regAddr(regAddr), .regData(regData),
    .callStrobe(callStrobe), .callVector(callVector),
    .flagState(flagState), .enState(enState), .gieState(gieState)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [N-1:0] d);
    regWr = 1'b1; regAddr = a; regData = d;
    @(negedge clk);
    regWr = 1'b0; regData = '0;
  endtask

  task automatic quiesce();
    wrReg(2'd3, '0);
    wrReg(2'd1, '1);
    wrReg(2'd2, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(flagState == 0 && enState == 0 && !gieState && !callStrobe, "R1",
        {flagState, enState, gieState, callStrobe}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Exhaustive sweep: R3 R4 R5 R6
    for (int f = 0; f < (1 << N); f++) begin
      for (int e = 0; e < (1 << N); e++) begin
        int pend, idx;
        bit strobeOk;
        quiesce();
        wrReg(2'd0, N'(f));
        wrReg(2'd2, N'(e));
        wrReg(2'd3, N'(1));
        @(negedge clk);
        pend = f & e;
        idx = -1;
        for (int i = N - 1; i >= 0; i--) if (pend[i]) idx = i;
        if (idx < 0) begin
          chk(!callStrobe && flagState == N'(f) && gieState, "R3",
              {callStrobe, flagState, gieState}, {1'b0, N'(f), 1'b1});
        end else begin
          chk(callStrobe && callVector == 8'(4 + 4 * idx), "R4",
              {callStrobe, callVector}, {1'b1, 8'(4 + 4 * idx)});
          chk(flagState == N'(f & ~(1 << idx)) && !gieState, "R5 R6",
              {flagState, gieState}, {N'(f & ~(1 << idx)), 1'b0});
        end
        @(negedge clk);
        strobeOk = !callStrobe;
        chk(strobeOk, "R4", callStrobe, 0);
      end
    end

    // R2: event sets sticky flag, enable 0, no call
    quiesce();
    wrReg(2'd3, N'(1));
    srcEvent = 5'b00100;
    @(negedge clk);
    srcEvent = '0;
    chk(flagState == 5'b00100, "R2", flagState, 5'b00100);
    repeat (4) @(negedge clk);
    chk(flagState == 5'b00100 && !callStrobe && gieState, "R2",
        {flagState, callStrobe}, {5'b00100, 1'b0});

    // R10: enabling a pending flag serves it
    wrReg(2'd2, 5'b00100);
    chk(callStrobe == 1'b0, "R10", callStrobe, 0);
    @(negedge clk);
    chk(callStrobe && callVector == 8'd12 && flagState == 0, "R10",
        {callStrobe, callVector}, {1'b1, 8'd12});

    // R7: stack full suppresses, nothing cleared
    quiesce();
    wrReg(2'd0, 5'b00010);
    wrReg(2'd2, 5'b00010);
    stackFull = 1'b1;
    wrReg(2'd3, N'(1));
    repeat (5) begin
      chk(!callStrobe, "R7", callStrobe, 0);
      @(negedge clk);
    end
    chk(flagState == 5'b00010 && gieState, "R7", {flagState, gieState}, {5'b00010, 1'b1});
    stackFull = 1'b0;
    @(negedge clk);
    chk(callStrobe && callVector == 8'd8, "R7", {callStrobe, callVector}, {1'b1, 8'd8});

    // R8: event in same cycle as service clear
    quiesce();
    wrReg(2'd0, 5'b00001);
    wrReg(2'd2, 5'b00001);
    wrReg(2'd3, N'(1));
    srcEvent = 5'b00001;
    @(negedge clk);
    srcEvent = '0;
    chk(callStrobe && flagState == 5'b00001 && !gieState, "R8",
        {callStrobe, flagState, gieState}, {1'b1, 5'b00001, 1'b0});

    // R8: event in same cycle as software clear
    quiesce();
    wrReg(2'd0, 5'b01010);
    srcEvent = 5'b00010;
    wrReg(2'd1, 5'b01010);
    srcEvent = '0;
    chk(flagState == 5'b00010, "R8", flagState, 5'b00010);

    // R9: register port decode
    quiesce();
    wrReg(2'd0, 5'b10011);
    chk(flagState == 5'b10011, "R9", flagState, 5'b10011);
    wrReg(2'd1, 5'b00010);
    chk(flagState == 5'b10001, "R9", flagState, 5'b10001);
    wrReg(2'd2, 5'b01100);
    chk(enState == 5'b01100, "R9", enState, 5'b01100);
    wrReg(2'd3, 5'b11110);
    chk(!gieState, "R9", gieState, 0);
    wrReg(2'd3, 5'b00001);
    chk(gieState && !callStrobe, "R9", gieState, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule